// File: doc/BRIEF.md
# Merged Unicast/Multicast Egress Class Queue Arbiter

This block holds the pending transmit work for one egress port, sorted by traffic class, and hands the port the next frame handle when the port can take it. Each class keeps unicast jobs as a linked list of descriptors. The linked lists of all classes share one descriptor pool, and free slots are tracked by a busy bitmap. Even-numbered classes also own a small physical FIFO for multicast entries. The FIFO with index m belongs to class 2m, so odd classes carry unicast traffic only.

The unicast list and the multicast FIFO of the same class act as one logical queue. Every entry gets a stamp from a free-running counter when it is enqueued. Between the two heads, the one with the older stamp goes first. Across classes, the highest-numbered class that holds any entry wins by strict priority.

An enqueue that finds no room, or that names multicast for an odd class, is dropped. A one-cycle overflow pulse reports the drop. Output uses a valid/ready handshake, and an entry leaves its queue only in a cycle where valid and ready are both high.

Top module: `txq_merge_arb`

## Requirements
- R1: After reset, `deq_valid` and `enq_overflow` are low, and every queue is empty.
- R2: Unicast entries of one class are dequeued in enqueue order, with `deq_mcast` = 0.
- R3: A multicast enqueue to an even class c is written into FIFO c/2 and is dequeued in FIFO order with `deq_mcast` = 1 and `deq_class` = c. A multicast enqueue to an odd class is dropped and raises `enq_overflow`.
- R4: When both the unicast head and the multicast head of a class are present, the entry with the older enqueue stamp is output first. On equal stamps, unicast is output first.
- R5: Among non-empty classes, the highest class index is output first, and class 0 has the lowest priority.
- R6: An entry is removed only in a cycle where `deq_valid` and `deq_ready` are both high. While `deq_ready` is low, `deq_valid` stays high and no entry is lost.
- R7: An empty class is never selected. When every queue is empty, `deq_valid` is low.
- R8: An enqueue that finds the descriptor pool full (unicast) or its FIFO full (multicast, MDEPTH entries) is dropped. `enq_overflow` is then high for exactly the cycle after the enqueue cycle.
- R9: With NCLS = 8, the multicast FIFOs serve classes 0, 2, 4 and 6. Class 7 ranks above class 6.
- R10: All classes share the POOL descriptors. A descriptor freed by a dequeue can be used by a later enqueue to any class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request in this cycle |
| enq_class | input | $clog2(NCLS) | Traffic class of the request |
| enq_mcast | input | 1 | 1 = multicast entry, 0 = unicast job |
| enq_handle | input | HW | Frame handle to store |
| enq_overflow | output | 1 | One-cycle pulse: the previous cycle's enqueue was dropped |
| deq_valid | output | 1 | A frame is offered |
| deq_ready | input | 1 | The port accepts the offered frame |
| deq_handle | output | HW | Handle of the offered frame |
| deq_class | output | $clog2(NCLS) | Class of the offered frame |
| deq_mcast | output | 1 | Offered frame came from a multicast FIFO |

## Verification
The assertions assume the following about the inputs:
- `enq_class` is always below NCLS.
- POOL and MDEPTH are powers of two.
- Two heads that compete for the same class never differ in age by half the stamp range or more. The wrap-safe comparison relies on this.

The stimulus keeps within these limits. Each scenario starts from a fresh reset and drains its entries within a few dozen cycles of enqueueing them, well below the 128-cycle half range of the 8-bit stamp. Only legal class indices are driven.

// File: rtl/txq_merge_arb.sv
module txq_merge_arb #(
  parameter int NCLS   = 8,
  parameter int HW     = 8,
  parameter int POOL   = 16,
  parameter int MDEPTH = 4,
  parameter int TSW    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enq_valid,
  input  logic [$clog2(NCLS)-1:0] enq_class,
  input  logic                    enq_mcast,
  input  logic [HW-1:0]           enq_handle,
  output logic                    enq_overflow,
  output logic                    deq_valid,
  input  logic                    deq_ready,
  output logic [HW-1:0]           deq_handle,
  output logic [$clog2(NCLS)-1:0] deq_class,
  output logic                    deq_mcast
);
  localparam int CW  = $clog2(NCLS);
  localparam int NMC = NCLS / 2;
  localparam int PW  = $clog2(POOL);
  localparam int MW  = $clog2(MDEPTH);
  localparam int UCW = $clog2(POOL + 1);
  localparam int MCW = $clog2(MDEPTH + 1);

  logic [TSW-1:0] tsc;
  logic [HW-1:0]  p_hdl [POOL];
  logic [TSW-1:0] p_ts  [POOL];
  logic [PW-1:0]  p_nxt [POOL];
  logic [POOL-1:0] busy;
  logic [PW-1:0]  u_head [NCLS];
  logic [PW-1:0]  u_tail [NCLS];
  logic [UCW-1:0] u_cnt  [NCLS];
  logic [HW-1:0]  m_hdl [NMC][MDEPTH];
  logic [TSW-1:0] m_ts  [NMC][MDEPTH];
  logic [MW-1:0]  m_wp [NMC];
  logic [MW-1:0]  m_rp [NMC];
  logic [MCW-1:0] m_cnt [NMC];

  logic [NCLS-1:0] u_ne, m_ne, pick_m, cls_ne;
  logic [HW-1:0]   mc_hd [NCLS];
  logic [PW-1:0]   free_idx;
  logic            pool_full;
  logic [CW-1:0]   sel;

  always_comb begin
    free_idx = '0;
    for (int i = POOL - 1; i >= 0; i--)
      if (!busy[i]) free_idx = PW'(i);
  end
  assign pool_full = &busy;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign u_ne[c] = (u_cnt[c] != '0);
    if (c % 2 == 0) begin : g_pair
      localparam int M = c / 2;
      logic [TSW-1:0] dlt;
      assign m_ne[c]  = (m_cnt[M] != '0);
      assign mc_hd[c] = m_hdl[M][m_rp[M]];
      assign dlt      = p_ts[u_head[c]] - m_ts[M][m_rp[M]];
      assign pick_m[c] = m_ne[c] && (!u_ne[c] || (dlt != '0 && !dlt[TSW-1]));
    end else begin : g_solo
      assign m_ne[c]   = 1'b0;
      assign mc_hd[c]  = '0;
      assign pick_m[c] = 1'b0;
    end
    assign cls_ne[c] = u_ne[c] | m_ne[c];
  end

  always_comb begin
    sel = '0;
    for (int c = 0; c < NCLS; c++)
      if (cls_ne[c]) sel = CW'(c);
  end

  assign deq_valid  = |cls_ne;
  assign deq_class  = sel;
  assign deq_mcast  = pick_m[sel];
  assign deq_handle = pick_m[sel] ? mc_hd[sel] : p_hdl[u_head[sel]];

  logic [CW-2:0] enq_mi, sel_mi;
  logic fire, pop_u, pop_m, ok_u, ok_m, acc, drop;
  assign enq_mi = enq_class[CW-1:1];
  assign sel_mi = sel[CW-1:1];
  assign fire   = deq_valid & deq_ready;
  assign pop_u  = fire & ~deq_mcast;
  assign pop_m  = fire & deq_mcast;
  assign ok_u   = ~enq_mcast & ~pool_full;
  assign ok_m   = enq_mcast & ~enq_class[0] & (m_cnt[enq_mi] != MCW'(MDEPTH));
  assign acc    = enq_valid & (ok_u | ok_m);
  assign drop   = enq_valid & ~(ok_u | ok_m);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsc          <= '0;
      busy         <= '0;
      enq_overflow <= 1'b0;
      for (int c = 0; c < NCLS; c++) begin
        u_cnt[c]  <= '0;
        u_head[c] <= '0;
        u_tail[c] <= '0;
      end
      for (int m = 0; m < NMC; m++) begin
        m_cnt[m] <= '0;
        m_wp[m]  <= '0;
        m_rp[m]  <= '0;
      end
    end else begin
      tsc          <= tsc + 1'b1;
      enq_overflow <= drop;
      if (pop_u) begin
        busy[u_head[sel]] <= 1'b0;
        u_head[sel]       <= p_nxt[u_head[sel]];
      end
      if (acc && !enq_mcast) begin
        busy[free_idx] <= 1'b1;
        if (u_cnt[enq_class] == '0 ||
            (u_cnt[enq_class] == UCW'(1) && pop_u && sel == enq_class))
          u_head[enq_class] <= free_idx;
        u_tail[enq_class] <= free_idx;
      end
      for (int c = 0; c < NCLS; c++)
        u_cnt[c] <= u_cnt[c]
                  + UCW'(acc && !enq_mcast && enq_class == CW'(c))
                  - UCW'(pop_u && sel == CW'(c));
      for (int m = 0; m < NMC; m++) begin
        m_cnt[m] <= m_cnt[m]
                  + MCW'(acc && enq_mcast && enq_mi == (CW-1)'(m))
                  - MCW'(pop_m && sel_mi == (CW-1)'(m));
        if (acc && enq_mcast && enq_mi == (CW-1)'(m)) m_wp[m] <= m_wp[m] + 1'b1;
        if (pop_m && sel_mi == (CW-1)'(m))           m_rp[m] <= m_rp[m] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc && !enq_mcast) begin
      p_hdl[free_idx] <= enq_handle;
      p_ts[free_idx]  <= tsc;
      if (u_cnt[enq_class] != '0) p_nxt[u_tail[enq_class]] <= free_idx;
    end
    if (acc && enq_mcast) begin
      m_hdl[enq_mi][m_wp[enq_mi]] <= enq_handle;
      m_ts[enq_mi][m_wp[enq_mi]]  <= tsc;
    end
  end

  int u_sum, all_sum;
  always_comb begin
    u_sum = 0;
    for (int c = 0; c < NCLS; c++) u_sum += int'(u_cnt[c]);
    all_sum = u_sum;
    for (int m = 0; m < NMC; m++) all_sum += int'(m_cnt[m]);
  end

  AST_POOL_ACCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(busy) == u_sum);  // R10
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    enq_overflow |-> $past(enq_valid));  // R8
  AST_HOLD_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && !deq_ready) |=> deq_valid);  // R6
  AST_NO_SILENT_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> all_sum >= $past(all_sum));  // R6
  AST_MC_EVEN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && deq_mcast) |-> !deq_class[0]);  // R3
  for (genvar m = 0; m < NMC; m++) begin : g_mchk
    AST_MC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      m_cnt[m] <= MCW'(MDEPTH));  // R8
  end
endmodule

// File: tb/txq_merge_arb_tb.sv
`timescale 1ns/1ps
module txq_merge_arb_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_valid = 1'b0, enq_mcast = 1'b0, deq_ready = 1'b0;
  logic [2:0] enq_class = '0;
  logic [7:0] enq_handle = '0;
  logic enq_overflow, deq_valid, deq_mcast;
  logic [7:0] deq_handle;
  logic [2:0] deq_class;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  txq_merge_arb u_dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_class(enq_class),
    .enq_mcast(enq_mcast), .enq_handle(enq_handle), .enq_overflow(enq_overflow),
    .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_handle(deq_handle),
    .deq_class(deq_class), .deq_mcast(deq_mcast));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; enq_valid = 1'b0; deq_ready = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic enq(int c, bit mc, int h, bit exp_drop, string tag);
    @(negedge clk);
    enq_valid = 1'b1; enq_class = 3'(c); enq_mcast = mc; enq_handle = 8'(h);
    @(negedge clk);
    enq_valid = 1'b0;
    chk({tag, " overflow"}, int'(enq_overflow), int'(exp_drop));
  endtask

  task automatic deq(int c, bit mc, int h, string tag);
    @(negedge clk);
    chk({tag, " valid"}, int'(deq_valid), 1);
    chk({tag, " class"}, int'(deq_class), c);
    chk({tag, " mcast"}, int'(deq_mcast), int'(mc));
    chk({tag, " handle"}, int'(deq_handle), h);
    deq_ready = 1'b1;
    @(negedge clk);
    deq_ready = 1'b0;
  endtask

  task automatic expect_empty(string tag);
    @(negedge clk);
    chk({tag, " empty"}, int'(deq_valid), 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 valid", int'(deq_valid), 0);
    chk("R1 overflow", int'(enq_overflow), 0);
    expect_empty("R7 after reset");
  endtask

  task automatic t_ucast_order();
    do_reset();
    for (int i = 0; i < 3; i++) enq(1, 0, 10 + i, 0, "R2 enq");
    for (int i = 0; i < 3; i++) deq(1, 0, 10 + i, "R2 order");
    expect_empty("R7 drained");
  endtask

  task automatic t_merge();
    do_reset();
    enq(2, 0, 20, 0, "R4 enq"); enq(2, 1, 21, 0, "R4 enq");
    enq(2, 0, 22, 0, "R4 enq"); enq(2, 1, 23, 0, "R4 enq");
    deq(2, 0, 20, "R4 u first"); deq(2, 1, 21, "R4 m older");
    deq(2, 0, 22, "R4 u older"); deq(2, 1, 23, "R3 m last");
    enq(0, 1, 30, 0, "R3 enq"); enq(0, 0, 31, 0, "R4 enq");
    deq(0, 1, 30, "R4 mcast older"); deq(0, 0, 31, "R4 ucast after");
    expect_empty("R7 merge drained");
  endtask

  task automatic t_priority();
    do_reset();
    enq(0, 0, 1, 0, "R5 enq"); enq(5, 0, 2, 0, "R5 enq");
    enq(3, 0, 3, 0, "R5 enq"); enq(6, 1, 4, 0, "R9 enq");
    enq(7, 0, 5, 0, "R9 enq");
    deq(7, 0, 5, "R9 top class"); deq(6, 1, 4, "R9 class6 mcast");
    deq(5, 0, 2, "R5 class5"); deq(3, 0, 3, "R5 class3");
    deq(0, 0, 1, "R5 class0");
    expect_empty("R7 prio drained");
  endtask

  task automatic t_hold();
    do_reset();
    enq(3, 0, 51, 0, "R6 enq");
    enq(0, 0, 52, 0, "R6 enq");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R6 held valid", int'(deq_valid), 1);
      chk("R6 held handle", int'(deq_handle), 51);
    end
    deq(3, 0, 51, "R6 pop"); deq(0, 0, 52, "R6 next");
    expect_empty("R6 drained");
  endtask

  task automatic t_mc_odd();
    do_reset();
    enq(3, 1, 60, 1, "R3 odd mcast dropped");
    @(negedge clk);
    chk("R8 overflow one cycle", int'(enq_overflow), 0);
    expect_empty("R3 odd not stored");
  endtask

  task automatic t_mc_full();
    do_reset();
    for (int i = 0; i < 4; i++) enq(4, 1, 70 + i, 0, "R8 mc fill");
    enq(4, 1, 79, 1, "R8 mc full drop");
    for (int i = 0; i < 4; i++) deq(4, 1, 70 + i, "R3 mc fifo order");
    expect_empty("R8 mc drained");
  endtask

  task automatic t_pool_full();
    do_reset();
    for (int i = 0; i < 8; i++) enq(1, 0, 100 + i, 0, "R10 fill");
    for (int i = 0; i < 8; i++) enq(0, 0, 120 + i, 0, "R10 fill");
    enq(2, 0, 140, 1, "R8 pool full drop");
    enq(2, 1, 141, 0, "R8 mc unaffected");
    deq(2, 1, 141, "R8 mc out");
    for (int i = 0; i < 8; i++) deq(1, 0, 100 + i, "R10 class1");
    for (int i = 0; i < 8; i++) deq(0, 0, 120 + i, "R10 class0");
    expect_empty("R10 drained");
    enq(5, 0, 150, 0, "R10 reuse");
    deq(5, 0, 150, "R10 reuse out");
  endtask

  initial begin
    t_reset();
    t_ucast_order();
    t_merge();
    t_priority();
    t_hold();
    t_mc_odd();
    t_mc_full();
    t_pool_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule